// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block is the issue stage of a SIMT core. It holds `NSCHED` warp schedulers, each owning `NWARP` warps. In every cycle each scheduler picks one warp and issues up to two instructions from the front of that warp's instruction buffer. The instructions go to three dispatch ports: the SP arithmetic pipe, the special-function (SFU) pipe and the memory pipe. Inside a scheduler, warps are tried oldest first, ranked by a dynamic age tag. Across schedulers the service order rotates every cycle, so no scheduler gets the scarce port slots more often than the others.

The dispatch ports apply back-pressure through credit counts. `sp_free`, `sfu_free` and `mem_free` give the number of slots each pipe accepts this cycle. An instruction is offered on a port only when a slot remains. Each slot that an earlier scheduler in the rotation claims is taken away from the later ones. Nothing is held or retried inside the block: an instruction that finds no slot simply stays in its buffer. The issue decision (`iss_*`) is combinational from the inputs of the same cycle. The rotation pointer and the per-scheduler single and dual issue counters are registers.

Top module: `wsched_issue`

## Requirements
- R1: After reset the rotation pointer is 0, and it advances by one, modulo `NSCHED`, on every clock edge out of reset. Scheduler `p` is served first, followed by `p+1`, `p+2` and so on in circular order.
- R2: Among the issuable warps of a scheduler, the one with the smallest `warp_age` wins. On equal ages, the lower local warp index wins.
- R3: A warp is issuable only when `warp_ready` is high, slot 0 of its buffer is valid, and the slot-0 instruction can be routed to a port that still has a slot left. Otherwise the next warp in age order is tried.
- R4: Class codes are routed as follows. Class 0 (arithmetic) goes to SP. Class 1 (special function) goes to SFU. Class 2 (either) goes to SP when possible and otherwise to SFU. Class 3 (load, store or barrier) goes to MEM.
- R5: The slot-1 instruction issues in the same cycle only when slot 0 issued, slot 1 is valid, `MAX_ISSUE` is 2, and it can be routed. With `DIFF_UNITS` set it must also target a unit type different from the slot-0 instruction. Otherwise the warp single-issues.
- R6: The unit codes on `iss_unit0` and `iss_unit1` are NONE=0, SP=1, SFU=2 and MEM=3. A scheduler that issues nothing shows NONE on both, with `iss_warp` equal to 0.
- R7: Each issued instruction consumes one slot of its port's free count for the cycle, in rotation order. The total claims on a port never exceed its free count.
- R8: A scheduler's single counter increments when it issues exactly one instruction. Its dual counter increments when it issues two. Neither changes when it issues nothing.
- R9: Reset clears both counter sets and the rotation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NSCHED*NWARP | Warp not waiting and scoreboard clear; warp `s*NWARP+j` is warp `j` of scheduler `s` |
| ib_valid | input | NSCHED*NWARP x 2 | Valid flags of the two front buffer slots |
| ib_class | input | NSCHED*NWARP x 2 x 2 | Class code of each front slot |
| warp_age | input | NSCHED*NWARP x IDW | Dynamic age tag; lower is older |
| sp_free | input | SLOTW | Free SP pipe slots this cycle |
| sfu_free | input | SLOTW | Free SFU pipe slots this cycle |
| mem_free | input | SLOTW | Free memory pipe slots this cycle |
| iss_warp | output | NSCHED x WW | Local index of the issuing warp per scheduler |
| iss_unit0 | output | NSCHED x 3 | Unit taken by the slot-0 instruction |
| iss_unit1 | output | NSCHED x 3 | Unit taken by the slot-1 instruction |
| single_cnt | output | NSCHED x CW | Single-issue counter per scheduler |
| dual_cnt | output | NSCHED x CW | Dual-issue counter per scheduler |

## Verification
Two mechanisms can act in the same cycle: the cross-scheduler port budget and the within-warp unit-type exclusion. When a dual issue takes two slots early in the rotation, a later scheduler may be left with no slot for its oldest warp and must fall through to a younger one. The bench provokes this with scarce free counts on warps that carry mixed classes, and also with fully random buffers. An age-ordered, rotation-aware bench model predicts every warp and unit code, both counters, and the claim totals per port.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef logic [2:0] unit_t;
  localparam unit_t U_NONE = 3'd0;
  localparam unit_t U_SP   = 3'd1;
  localparam unit_t U_SFU  = 3'd2;
  localparam unit_t U_MEM  = 3'd3;
  localparam unit_t U_DP   = 3'd4;

  localparam logic [1:0] OP_ALU  = 2'd0;
  localparam logic [1:0] OP_SFU  = 2'd1;
  localparam logic [1:0] OP_EITH = 2'd2;
  localparam logic [1:0] OP_MEM  = 2'd3;

  // Chooses a target unit for one instruction; prev is the unit used just before in this warp.
  function automatic unit_t route(input logic [1:0] cls, input unit_t prev,
                                  input logic sp_ok, input logic sfu_ok,
                                  input logic mem_ok, input logic excl);
    logic sp_en, sfu_en, mem_en;
    sp_en  = sp_ok  && !(excl && prev == U_SP);
    sfu_en = sfu_ok && !(excl && prev == U_SFU);
    mem_en = mem_ok && !(excl && prev == U_MEM);
    unique case (cls)
      OP_ALU:  return sp_en  ? U_SP  : U_NONE;
      OP_SFU:  return sfu_en ? U_SFU : U_NONE;
      OP_EITH: return sp_en  ? U_SP  : (sfu_en ? U_SFU : U_NONE);
      default: return mem_en ? U_MEM : U_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wsched_pick.sv
module wsched_pick
  import wsched_pkg::*;
#(
  parameter int NWARP      = 4,
  parameter int IDW        = 6,
  parameter int SLOTW      = 2,
  parameter int MAX_ISSUE  = 2,
  parameter bit DIFF_UNITS = 1'b1,
  localparam int WW = (NWARP > 1) ? $clog2(NWARP) : 1
) (
  input  logic [NWARP-1:0]                ready,
  input  logic [NWARP-1:0][1:0]           vld,
  input  logic [NWARP-1:0][1:0][1:0]      cls,
  input  logic [NWARP-1:0][IDW-1:0]       age,
  input  logic [2:0][SLOTW-1:0]           avail_in,
  output logic [WW-1:0]                   warp,
  output logic [2:0]                      unit0,
  output logic [2:0]                      unit1,
  output logic [2:0][SLOTW-1:0]           avail_out
);
  function automatic logic [2:0][SLOTW-1:0] take(input logic [2:0][SLOTW-1:0] a,
                                                 input unit_t u);
    logic [2:0][SLOTW-1:0] r;
    r = a;
    case (u)
      U_SP:    r[0] = a[0] - SLOTW'(1);
      U_SFU:   r[1] = a[1] - SLOTW'(1);
      U_MEM:   r[2] = a[2] - SLOTW'(1);
      default: r = a;
    endcase
    return r;
  endfunction

  logic                  found;
  logic [WW-1:0]         best;
  logic [IDW-1:0]        best_age;
  logic [2:0][SLOTW-1:0] mid;
  unit_t                 u0, u1;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_age = '0;
    for (int j = 0; j < NWARP; j++) begin
      if (ready[j] && vld[j][0] &&
          route(cls[j][0], U_NONE, avail_in[0] != '0, avail_in[1] != '0,
                avail_in[2] != '0, DIFF_UNITS) != U_NONE &&
          (!found || age[j] < best_age)) begin
        found    = 1'b1;
        best     = WW'(j);
        best_age = age[j];
      end
    end
    u0 = found ? route(cls[best][0], U_NONE, avail_in[0] != '0, avail_in[1] != '0,
                       avail_in[2] != '0, DIFF_UNITS) : U_NONE;
    mid = take(avail_in, u0);
    u1  = U_NONE;
    if (found && MAX_ISSUE > 1 && vld[best][1])
      u1 = route(cls[best][1], u0, mid[0] != '0, mid[1] != '0, mid[2] != '0, DIFF_UNITS);
    avail_out = take(mid, u1);
    warp  = best;
    unit0 = u0;
    unit1 = u1;
  end
endmodule

// File: rtl/wsched_tally.sv
module wsched_tally
  import wsched_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    unit0,
  input  logic [2:0]    unit1,
  output logic [CW-1:0] single_q,
  output logic [CW-1:0] dual_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_q <= '0;
      dual_q   <= '0;
    end else if (unit1 != U_NONE) begin
      dual_q <= dual_q + CW'(1);
    end else if (unit0 != U_NONE) begin
      single_q <= single_q + CW'(1);
    end
  end
endmodule

// File: rtl/wsched_issue.sv
module wsched_issue
  import wsched_pkg::*;
#(
  parameter int NSCHED     = 2,
  parameter int NWARP      = 4,
  parameter int IDW        = 6,
  parameter int SLOTW      = 2,
  parameter int CW         = 16,
  parameter int MAX_ISSUE  = 2,
  parameter bit DIFF_UNITS = 1'b1,
  localparam int NW = NSCHED * NWARP,
  localparam int WW = (NWARP > 1) ? $clog2(NWARP) : 1,
  localparam int PW = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NW-1:0]                   warp_ready,
  input  logic [NW-1:0][1:0]              ib_valid,
  input  logic [NW-1:0][1:0][1:0]         ib_class,
  input  logic [NW-1:0][IDW-1:0]          warp_age,
  input  logic [SLOTW-1:0]                sp_free,
  input  logic [SLOTW-1:0]                sfu_free,
  input  logic [SLOTW-1:0]                mem_free,
  output logic [NSCHED-1:0][WW-1:0]       iss_warp,
  output logic [NSCHED-1:0][2:0]          iss_unit0,
  output logic [NSCHED-1:0][2:0]          iss_unit1,
  output logic [NSCHED-1:0][CW-1:0]       single_cnt,
  output logic [NSCHED-1:0][CW-1:0]       dual_cnt
);
  logic [PW-1:0] prio;

  // Rotation pointer: first scheduler served this cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                          prio <= '0;
    else if (int'(prio) == NSCHED - 1)   prio <= '0;
    else                                 prio <= prio + PW'(1);
  end

  // Position k of the rotation serves scheduler (prio + k) mod NSCHED.
  int                                   pos_sched [NSCHED];
  logic [NSCHED-1:0][NWARP-1:0]         p_ready;
  logic [NSCHED-1:0][NWARP-1:0][1:0]    p_vld;
  logic [NSCHED-1:0][NWARP-1:0][1:0][1:0] p_cls;
  logic [NSCHED-1:0][NWARP-1:0][IDW-1:0] p_age;
  logic [NSCHED-1:0][WW-1:0]            p_warp;
  logic [NSCHED-1:0][2:0]               p_u0, p_u1;
  logic [2:0][SLOTW-1:0]                chain [NSCHED+1];

  always_comb begin
    for (int k = 0; k < NSCHED; k++) begin
      pos_sched[k] = (int'(prio) + k) % NSCHED;
      for (int j = 0; j < NWARP; j++) begin
        p_ready[k][j] = warp_ready[pos_sched[k]*NWARP + j];
        p_vld[k][j]   = ib_valid[pos_sched[k]*NWARP + j];
        p_cls[k][j]   = ib_class[pos_sched[k]*NWARP + j];
        p_age[k][j]   = warp_age[pos_sched[k]*NWARP + j];
      end
    end
  end

  assign chain[0] = {mem_free, sfu_free, sp_free};

  for (genvar k = 0; k < NSCHED; k++) begin : g_pos
    wsched_pick #(
      .NWARP(NWARP), .IDW(IDW), .SLOTW(SLOTW),
      .MAX_ISSUE(MAX_ISSUE), .DIFF_UNITS(DIFF_UNITS)
    ) u_pick (
      .ready    (p_ready[k]),
      .vld      (p_vld[k]),
      .cls      (p_cls[k]),
      .age      (p_age[k]),
      .avail_in (chain[k]),
      .warp     (p_warp[k]),
      .unit0    (p_u0[k]),
      .unit1    (p_u1[k]),
      .avail_out(chain[k+1])
    );
  end

  always_comb begin
    iss_warp  = '0;
    iss_unit0 = '0;
    iss_unit1 = '0;
    for (int k = 0; k < NSCHED; k++) begin
      iss_warp[pos_sched[k]]  = (p_u0[k] != U_NONE) ? p_warp[k] : '0;
      iss_unit0[pos_sched[k]] = p_u0[k];
      iss_unit1[pos_sched[k]] = p_u1[k];
    end
  end

  for (genvar s = 0; s < NSCHED; s++) begin : g_tally
    wsched_tally #(.CW(CW)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .unit0   (iss_unit0[s]),
      .unit1   (iss_unit1[s]),
      .single_q(single_cnt[s]),
      .dual_q  (dual_cnt[s])
    );
  end
endmodule

// File: rtl/wsched_issue_chk.sv
module wsched_issue_chk
  import wsched_pkg::*;
#(
  parameter int NSCHED = 2,
  parameter int NWARP  = 4,
  parameter int SLOTW  = 2,
  parameter int CW     = 16,
  localparam int NW = NSCHED * NWARP,
  localparam int WW = (NWARP > 1) ? $clog2(NWARP) : 1,
  localparam int PW = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [PW-1:0]             prio,
  input logic [NW-1:0]             warp_ready,
  input logic [NW-1:0][1:0]        ib_valid,
  input logic [SLOTW-1:0]          sp_free,
  input logic [SLOTW-1:0]          sfu_free,
  input logic [SLOTW-1:0]          mem_free,
  input logic [NSCHED-1:0][WW-1:0] iss_warp,
  input logic [NSCHED-1:0][2:0]    iss_unit0,
  input logic [NSCHED-1:0][2:0]    iss_unit1,
  input logic [NSCHED-1:0][CW-1:0] single_cnt,
  input logic [NSCHED-1:0][CW-1:0] dual_cnt
);
  int sp_cl, sfu_cl, mem_cl;
  always_comb begin
    sp_cl = 0; sfu_cl = 0; mem_cl = 0;
    for (int s = 0; s < NSCHED; s++) begin
      sp_cl  += int'(iss_unit0[s] == U_SP)  + int'(iss_unit1[s] == U_SP);
      sfu_cl += int'(iss_unit0[s] == U_SFU) + int'(iss_unit1[s] == U_SFU);
      mem_cl += int'(iss_unit0[s] == U_MEM) + int'(iss_unit1[s] == U_MEM);
    end
  end

  assert_port_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_cl <= int'(sp_free) && sfu_cl <= int'(sfu_free) && mem_cl <= int'(mem_free));

  assert_rotate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(prio) == (int'($past(prio)) + 1) % NSCHED);

  for (genvar s = 0; s < NSCHED; s++) begin : g_s
    assert_distinct_units_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit1[s] != U_NONE |-> iss_unit0[s] != U_NONE && iss_unit0[s] != iss_unit1[s]);

    assert_ready_warp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit0[s] != U_NONE |->
        warp_ready[s*NWARP + int'(iss_warp[s])] && ib_valid[s*NWARP + int'(iss_warp[s])][0]);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit0[s] == U_NONE |=> $stable(single_cnt[s]) && $stable(dual_cnt[s]));

    assert_dual_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit1[s] != U_NONE |=>
        dual_cnt[s] == CW'($past(dual_cnt[s]) + CW'(1)) && $stable(single_cnt[s]));
  end
endmodule

bind wsched_issue wsched_issue_chk #(
  .NSCHED(NSCHED), .NWARP(NWARP), .SLOTW(SLOTW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prio(prio), .warp_ready(warp_ready), .ib_valid(ib_valid),
  .sp_free(sp_free), .sfu_free(sfu_free), .mem_free(mem_free), .iss_warp(iss_warp),
  .iss_unit0(iss_unit0), .iss_unit1(iss_unit1), .single_cnt(single_cnt), .dual_cnt(dual_cnt)
);

// File: tb/wsched_issue_test.sv
module wsched_issue_test;
  localparam int NS = 2, NWP = 4, NW = NS * NWP, IDW = 6, SW = 2, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0]           rdy;
  logic [NW-1:0][1:0]      vld;
  logic [NW-1:0][1:0][1:0] cls;
  logic [NW-1:0][IDW-1:0]  age;
  logic [SW-1:0]           spf, sff, mmf;
  logic [NS-1:0][1:0]      iw;
  logic [NS-1:0][2:0]      u0, u1;
  logic [NS-1:0][CW-1:0]   sc, dc;

  int errs = 0, checks = 0, mprio = 0;
  int e_w[NS], e_u0[NS], e_u1[NS], e_sc[NS], e_dc[NS];
  bit done = 1'b0;

  always #(4ns) clk = ~clk;

  wsched_issue uut (
    .clk(clk), .rst_n(rst_n), .warp_ready(rdy), .ib_valid(vld), .ib_class(cls),
    .warp_age(age), .sp_free(spf), .sfu_free(sff), .mem_free(mmf),
    .iss_warp(iw), .iss_unit0(u0), .iss_unit1(u1), .single_cnt(sc), .dual_cnt(dc)
  );

  // Unit codes: 0 none, 1 SP, 2 SFU, 3 MEM.
  function automatic int b_route(int c, int prev, int a0, int a1, int a2);
    bit ok_sp, ok_sf, ok_mm;
    ok_sp = a0 > 0 && prev != 1;
    ok_sf = a1 > 0 && prev != 2;
    ok_mm = a2 > 0 && prev != 3;
    case (c)
      0: return ok_sp ? 1 : 0;
      1: return ok_sf ? 2 : 0;
      2: return ok_sp ? 1 : (ok_sf ? 2 : 0);
      default: return ok_mm ? 3 : 0;
    endcase
  endfunction

  task automatic model_eval();
    int av[3];
    av[0] = int'(spf); av[1] = int'(sff); av[2] = int'(mmf);
    for (int k = 0; k < NS; k++) begin
      int s, best, w, r0, r1;
      s = (mprio + k) % NS;
      best = -1;
      for (int j = 0; j < NWP; j++) begin
        w = s*NWP + j;
        if (rdy[w] && vld[w][0] && b_route(int'(cls[w][0]), 0, av[0], av[1], av[2]) != 0)
          if (best < 0 || age[w] < age[s*NWP + best]) best = j;
      end
      e_w[s] = 0; e_u0[s] = 0; e_u1[s] = 0;
      if (best >= 0) begin
        w = s*NWP + best;
        r0 = b_route(int'(cls[w][0]), 0, av[0], av[1], av[2]);
        av[r0-1]--;
        r1 = vld[w][1] ? b_route(int'(cls[w][1]), r0, av[0], av[1], av[2]) : 0;
        if (r1 != 0) av[r1-1]--;
        e_w[s] = best; e_u0[s] = r0; e_u1[s] = r1;
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs must already be driven after a falling edge.
  task automatic step(string tag);
    int c0, c1, c2;
    #(2ns);
    model_eval();
    for (int s = 0; s < NS; s++) begin
      chk(tag, $sformatf("sched%0d warp", s), int'(iw[s]), e_w[s]);
      chk(tag, $sformatf("sched%0d unit0", s), int'(u0[s]), e_u0[s]);
      chk(tag, $sformatf("sched%0d unit1", s), int'(u1[s]), e_u1[s]);
    end
    c0 = 0; c1 = 0; c2 = 0;
    for (int s = 0; s < NS; s++) begin
      c0 += int'(u0[s] == 1) + int'(u1[s] == 1);
      c1 += int'(u0[s] == 2) + int'(u1[s] == 2);
      c2 += int'(u0[s] == 3) + int'(u1[s] == 3);
    end
    chk("R7", "claims within budget", int'(c0 <= int'(spf) && c1 <= int'(sff) && c2 <= int'(mmf)), 1);
    @(posedge clk);
    if (rst_n) begin
      for (int s = 0; s < NS; s++) begin
        if (e_u1[s] != 0) e_dc[s]++;
        else if (e_u0[s] != 0) e_sc[s]++;
      end
      mprio = (mprio + 1) % NS;
    end
    #(1ns);
    for (int s = 0; s < NS; s++) begin
      chk("R8", $sformatf("sched%0d single", s), int'(sc[s]), e_sc[s]);
      chk("R8", $sformatf("sched%0d dual", s), int'(dc[s]), e_dc[s]);
    end
  endtask

  task automatic idle();
    rdy = '0; vld = '0; cls = '0; spf = 2'd3; sff = 2'd3; mmf = 2'd3;
    for (int w = 0; w < NW; w++) age[w] = IDW'(w);
  endtask

  task automatic setw(int w, int a, int v, int c0, int c1);
    rdy[w] = 1'b1; age[w] = IDW'(a); vld[w] = 2'(v);
    cls[w][0] = 2'(c0); cls[w][1] = 2'(c1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < NS; s++) begin e_sc[s] = 0; e_dc[s] = 0; end
    idle();
    // R9: counters clear during reset
    repeat (3) @(posedge clk);
    #(1ns);
    for (int s = 0; s < NS; s++) begin
      chk("R9", "reset single", int'(sc[s]), 0);
      chk("R9", "reset dual", int'(dc[s]), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R6: no ready warp gives NONE codes
    step("R6");
    // R1: one SP slot contended, winner alternates with the pointer
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); idle(); spf = 2'd1;
      setw(0, 5, 1, 0, 0); setw(NWP, 5, 1, 0, 0);
      step("R1");
    end
    // R2: oldest first, ties to lower index
    @(negedge clk); idle();
    setw(0, 9, 1, 0, 0); setw(1, 3, 1, 0, 0); setw(2, 7, 1, 0, 0); setw(3, 3, 1, 0, 0);
    step("R2");
    // R3: older warps not issuable (slot invalid, port exhausted)
    @(negedge clk); idle(); mmf = 2'd0;
    setw(0, 1, 0, 0, 0); setw(1, 2, 1, 3, 0); setw(2, 4, 1, 1, 0);
    step("R3");
    // R4: class 2 falls back to SFU when SP full
    @(negedge clk); idle(); spf = 2'd0;
    setw(NWP+1, 2, 1, 2, 0);
    step("R4");
    // R5: same-unit pair single-issues; mixed pair dual-issues
    @(negedge clk); idle();
    setw(0, 1, 3, 0, 0); setw(NWP, 1, 3, 0, 3);
    step("R5");
    @(negedge clk); idle();
    setw(0, 1, 3, 2, 2); setw(NWP+2, 1, 3, 3, 1);
    step("R5");
    // R7: single slots per port, second scheduler starved
    @(negedge clk); idle(); spf = 2'd1; sff = 2'd1; mmf = 2'd1;
    setw(0, 1, 3, 3, 2); setw(NWP, 1, 3, 2, 3); setw(NWP+1, 2, 1, 1, 0);
    step("R7");
    @(negedge clk); idle(); spf = 2'd1; sff = 2'd1; mmf = 2'd1;
    setw(0, 1, 3, 3, 2); setw(NWP, 1, 3, 2, 3); setw(NWP+1, 2, 1, 1, 0);
    step("R7");
    // Random mix, scarce credits; counters (R8) and routing (R4)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int w = 0; w < NW; w++) begin
        rdy[w] = 1'($urandom);
        vld[w] = 2'($urandom);
        cls[w] = 4'($urandom);
        age[w] = IDW'($urandom);
      end
      spf = 2'($urandom); sff = 2'($urandom); mmf = 2'($urandom);
      step("R4");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(1000us);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule